// File: doc/BRIEF.md
# Locking Cache Line-State and Maintenance Controller

This block holds the per-line bookkeeping of a 32-way set-associative data cache with 32 sets of 32-byte lines, for 32 KB in all. Each line has a valid flag and a lock flag. A single round-robin replacement pointer is shared by every set. The block does not store tags or data. An external tag-compare stage presents a set index and a one-hot vector of the ways whose tags match. The block answers in the same cycle with a hit flag and the way that hit, taking both the valid flags and the global enable into account.

Maintenance and fill commands arrive one at a time over a valid/ready handshake. An entry invalidate drops one line's valid flag. A lock command pins a line. An allocation picks the next way after the pointer that is not pinned. A whole-cache invalidate spares pinned lines. A whole-cache unlock releases every pin. The two whole-cache commands walk the sets one per cycle and hold ready low while they run. A pinned line survives both kinds of invalidate and can only be released by the unlock command or by reset.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable is off, every line is invalid and unlocked, cmd_ready is 1, and the replacement pointer holds 31, so the first successful allocation returns way 0.
- R2: A write on the configuration port loads the enable from bit 2 of cfg_wdata, and cfg_en shows it. While the enable is 0, lk_hit stays 0, and an allocate command changes nothing and raises neither alloc_ok nor alloc_full.
- R3: lk_hit is 1 in the same cycle when the enable, lk_valid and at least one way that is both valid in set lk_set and set in lk_match are all true. lk_hit_way is the lowest such way.
- R4: An accepted allocate command (cmd_op=5) searches the ways pointer+1, pointer+2 and so on, wrapping from 31 to 0, and takes the first one that is not locked in cmd_set. It marks that way valid and moves the pointer to it. In the next cycle alloc_ok is 1 for exactly one cycle and alloc_way shows the chosen way.
- R5: If every way of the addressed set is locked, an allocate command raises alloc_full for one cycle and leaves the pointer and the line state unchanged. alloc_ok and alloc_full are never 1 together.
- R6: A lock command (cmd_op=4) sets both the valid flag and the lock flag of the way cmd_way in set cmd_set, and does not move the pointer.
- R7: An entry-invalidate command (cmd_op=1) clears the valid flag of the way cmd_way in set cmd_set. If that line is locked, its lock flag stays set and allocation keeps skipping it.
- R8: A whole-cache invalidate (cmd_op=2) clears the valid flags of unlocked lines only. cmd_ready is low for exactly 32 cycles after the command is accepted.
- R9: A whole-cache unlock (cmd_op=3) clears every lock flag within 32 cycles, with cmd_ready low for that time. Afterwards the freed lines can be allocated and are removed by a later whole-cache invalidate.
- R10: A command is taken only in a cycle where cmd_valid and cmd_ready are both 1. A command presented while ready is low has no effect. Op codes 0, 6 and 7 do nothing.
- R11: A lookup reads the line state as it stood before the clock edge, so a command accepted in the same cycle changes the lookup result only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word; bit 2 is the cache enable |
| cfg_en | output | 1 | Current cache enable |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | 1 invalidate entry, 2 invalidate all, 3 unlock all, 4 lock line, 5 allocate |
| cmd_set | input | 5 | Set addressed by the command |
| cmd_way | input | 5 | Way addressed by invalidate-entry and lock |
| lk_valid | input | 1 | Lookup present |
| lk_set | input | 5 | Set of the lookup |
| lk_match | input | 32 | One bit per way whose tag matches |
| lk_hit | output | 1 | Lookup hit |
| lk_hit_way | output | 5 | Way that hit |
| alloc_ok | output | 1 | One-cycle pulse: allocation done |
| alloc_full | output | 1 | One-cycle pulse: every way of the set is locked |
| alloc_way | output | 5 | Way chosen by the last allocation |

## Verification
A lookup and a state-changing command can fall in the same cycle, and so can a lookup and a step of a set sweep. The bench raises a lookup on a valid line in the same cycle as an entry invalidate of that very line. It expects a hit before the clock edge and a miss after it. The bench also drives an allocate while a sweep holds ready low, and it judges from the response outputs and from the next allocation's way that the allocate was dropped.

// File: rtl/cmc_pkg.sv
// Shared constants and the command encoding for the cache maintenance controller.
package cmc_pkg;
    localparam int CMC_WAYS   = 32;
    localparam int CMC_SETS   = 32;
    localparam int CMC_EN_BIT = 2;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_INV_ENTRY  = 3'd1,
        OP_INV_ALL    = 3'd2,
        OP_UNLOCK_ALL = 3'd3,
        OP_LOCK       = 3'd4,
        OP_ALLOC      = 3'd5
    } cmc_op_e;
endpackage

// File: rtl/cmc_sweep.sv
// Set walker for whole-cache commands: visits one set per cycle, starting at set 0.
// Assumes a start request comes only while the walker is idle.
module cmc_sweep #(
    parameter int SETS  = cmc_pkg::CMC_SETS,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_inv,
    input  logic             start_unl,
    output logic             busy,
    output logic             kind_unl,
    output logic [SET_W-1:0] idx
);
    localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

    // Walk state: start, advance, and stop after the last set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            kind_unl <= 1'b0;
            idx      <= '0;
        end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx == LAST) busy <= 1'b0;
        end else if (start_inv || start_unl) begin
            busy     <= 1'b1;
            kind_unl <= start_unl;
            idx      <= '0;
        end
    end

    // R8
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_inv || start_unl)) |=> (busy && idx == '0));
    // R9
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx == LAST) |=> !busy);
endmodule

// File: rtl/cmc_line_state.sv
// Valid and lock flags for every line, updated by single-line commands and by the set walker.
// Assumes single-line commands never coincide with a sweep step (ready is low then).
module cmc_line_state #(
    parameter int WAYS  = cmc_pkg::CMC_WAYS,
    parameter int SETS  = cmc_pkg::CMC_SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_go,
    input  logic             lock_go,
    input  logic             alloc_go,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             sweep_busy,
    input  logic             sweep_unl,
    input  logic [SET_W-1:0] sweep_idx,
    input  logic [SET_W-1:0] lk_set,
    output logic [WAYS-1:0]  lk_valid_row,
    output logic [WAYS-1:0]  cmd_lock_row
);
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] lock_q  [SETS];

    // Flag storage: reset clears all, sweeps act per row, commands act per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (sweep_busy && sweep_idx == SET_W'(s)) begin
                    if (sweep_unl) lock_q[s]  <= '0;
                    else           valid_q[s] <= valid_q[s] & lock_q[s];
                end
            end
            if (inv_go) valid_q[cmd_set][cmd_way] <= 1'b0;
            if (lock_go) begin
                valid_q[cmd_set][cmd_way] <= 1'b1;
                lock_q[cmd_set][cmd_way]  <= 1'b1;
            end
            if (alloc_go) valid_q[cmd_set][fill_way] <= 1'b1;
        end
    end

    // Read ports: one row for the lookup, one for the victim search.
    always_comb begin
        lk_valid_row = valid_q[lk_set];
        cmd_lock_row = lock_q[cmd_set];
    end

    // R7
    inv_entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_go |=> !valid_q[$past(cmd_set)][$past(cmd_way)]);
    // R7
    inv_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_go && cmd_lock_row[cmd_way]) |=> lock_q[$past(cmd_set)][$past(cmd_way)]);
    // R6
    lock_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_go |=> (valid_q[$past(cmd_set)][$past(cmd_way)] && lock_q[$past(cmd_set)][$past(cmd_way)]));
    // R8
    sweep_inv_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_busy && !sweep_unl) |=> ((valid_q[$past(sweep_idx)] & ~lock_q[$past(sweep_idx)]) == '0));
    // R9
    sweep_unl_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_busy && sweep_unl) |=> (lock_q[$past(sweep_idx)] == '0));
endmodule

// File: rtl/cmc_victim.sv
// Round-robin victim search: first unlocked way after the pointer, wrapping at the top.
// Purely combinational; assumes WAYS is a power of two.
module cmc_victim #(
    parameter int WAYS  = cmc_pkg::CMC_WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAY_W-1:0] ptr,
    input  logic [WAYS-1:0]  lock_row,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] cand;

    // Scan the ways in rotated order and keep the first free one.
    always_comb begin
        found = 1'b0;
        way   = ptr;
        cand  = '0;
        for (int k = 1; k <= WAYS; k++) begin
            cand = WAY_W'((int'(ptr) + k) % WAYS);
            if (!found && !lock_row[cand]) begin
                found = 1'b1;
                way   = cand;
            end
        end
    end
endmodule

// File: rtl/cmc_hit.sv
// Hit detection: qualifies the tag-match vector with the valid row and the enable.
// Purely combinational; the lowest matching way wins if several match.
module cmc_hit #(
    parameter int WAYS  = cmc_pkg::CMC_WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             en,
    input  logic             lk_valid,
    input  logic [WAYS-1:0]  valid_row,
    input  logic [WAYS-1:0]  match,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    logic [WAYS-1:0] qual;

    // Encode the lowest qualified way by scanning downward.
    always_comb begin
        qual    = valid_row & match & {WAYS{en & lk_valid}};
        hit     = |qual;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (qual[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_maint_ctrl.sv
// Top of the locking cache maintenance controller: command handshake, enable register,
// shared replacement pointer and allocation response. Tags and data live elsewhere.
module cache_maint_ctrl #(
    parameter int WAYS  = cmc_pkg::CMC_WAYS,
    parameter int SETS  = cmc_pkg::CMC_SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic             cfg_en,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic [WAYS-1:0]  lk_match,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_hit_way,
    output logic             alloc_ok,
    output logic             alloc_full,
    output logic [WAY_W-1:0] alloc_way
);
    import cmc_pkg::*;

    logic             accept, sweep_busy, sweep_unl;
    logic [SET_W-1:0] sweep_idx;
    logic             inv_go, lock_go, alloc_go, full_go, start_inv, start_unl;
    logic [WAYS-1:0]  lk_row, lock_row;
    logic             vic_found;
    logic [WAY_W-1:0] vic_way, ptr_q;

    // Handshake and command decode.
    always_comb begin
        cmd_ready = !sweep_busy;
        accept    = cmd_valid && cmd_ready;
        inv_go    = accept && cmd_op == OP_INV_ENTRY;
        lock_go   = accept && cmd_op == OP_LOCK;
        start_inv = accept && cmd_op == OP_INV_ALL;
        start_unl = accept && cmd_op == OP_UNLOCK_ALL;
        alloc_go  = accept && cmd_op == OP_ALLOC && cfg_en && vic_found;
        full_go   = accept && cmd_op == OP_ALLOC && cfg_en && !vic_found;
    end

    // Enable register loaded from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_en <= 1'b0;
        else if (cfg_we) cfg_en <= cfg_wdata[CMC_EN_BIT];
    end

    // Replacement pointer and the registered allocation response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= WAY_W'(WAYS - 1);
            alloc_ok   <= 1'b0;
            alloc_full <= 1'b0;
            alloc_way  <= '0;
        end else begin
            alloc_ok   <= alloc_go;
            alloc_full <= full_go;
            if (alloc_go) begin
                ptr_q     <= vic_way;
                alloc_way <= vic_way;
            end
        end
    end

    cmc_sweep #(.SETS(SETS)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start_inv(start_inv), .start_unl(start_unl),
        .busy(sweep_busy), .kind_unl(sweep_unl), .idx(sweep_idx)
    );

    cmc_line_state #(.WAYS(WAYS), .SETS(SETS)) u_state (
        .clk(clk), .rst_n(rst_n), .inv_go(inv_go), .lock_go(lock_go), .alloc_go(alloc_go),
        .cmd_set(cmd_set), .cmd_way(cmd_way), .fill_way(vic_way),
        .sweep_busy(sweep_busy), .sweep_unl(sweep_unl), .sweep_idx(sweep_idx),
        .lk_set(lk_set), .lk_valid_row(lk_row), .cmd_lock_row(lock_row)
    );

    cmc_victim #(.WAYS(WAYS)) u_victim (
        .ptr(ptr_q), .lock_row(lock_row), .found(vic_found), .way(vic_way)
    );

    cmc_hit #(.WAYS(WAYS)) u_hit (
        .en(cfg_en), .lk_valid(lk_valid), .valid_row(lk_row), .match(lk_match),
        .hit(lk_hit), .hit_way(lk_hit_way)
    );

    // R2
    no_hit_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !lk_hit);
    // R4
    ptr_follows_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (ptr_q == alloc_way));
    // R5
    ok_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ok && alloc_full));
    // R5
    full_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_go |=> $stable(ptr_q));
    // R6
    lock_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_go |=> $stable(ptr_q));
    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |=> !alloc_ok);
endmodule

// File: tb/cache_maint_ctrl_test.sv
module cache_maint_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_en;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_set = '0, cmd_way = '0;
    logic        lk_valid = 1'b0;
    logic [4:0]  lk_set = '0;
    logic [31:0] lk_match = '0;
    logic        lk_hit;
    logic [4:0]  lk_hit_way;
    logic        alloc_ok, alloc_full;
    logic [4:0]  alloc_way;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cache_maint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_en(cfg_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_set(cmd_set),
        .cmd_way(cmd_way), .lk_valid(lk_valid), .lk_set(lk_set), .lk_match(lk_match),
        .lk_hit(lk_hit), .lk_hit_way(lk_hit_way), .alloc_ok(alloc_ok),
        .alloc_full(alloc_full), .alloc_way(alloc_way)
    );

    // Vector: op(3) set(5) way(5) exp_ok(1) exp_full(1) exp_way(5)
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {3'd5, 5'd5, 5'd0, 1'b1, 1'b0, 5'd0},
        {3'd5, 5'd5, 5'd0, 1'b1, 1'b0, 5'd1},
        {3'd4, 5'd5, 5'd2, 1'b0, 1'b0, 5'd0},
        {3'd5, 5'd5, 5'd0, 1'b1, 1'b0, 5'd3},
        {3'd4, 5'd9, 5'd0, 1'b0, 1'b0, 5'd0},
        {3'd5, 5'd9, 5'd0, 1'b1, 1'b0, 5'd4},
        {3'd1, 5'd5, 5'd1, 1'b0, 1'b0, 5'd0},
        {3'd5, 5'd5, 5'd0, 1'b1, 1'b0, 5'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue a command; returns at the negedge after the accepting edge.
    task automatic issue(input logic [2:0] op, input logic [4:0] s, input logic [4:0] w);
        @(negedge clk);
        cmd_op = op; cmd_set = s; cmd_way = w; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [4:0] s, input logic [31:0] m);
        lk_valid = 1'b1; lk_set = s; lk_match = m;
        #1;
    endtask

    task automatic alloc_expect(input string req, input logic [4:0] s, input logic [4:0] w);
        issue(3'd5, s, 5'd0);
        check(req, 32'(alloc_ok), 32'd1);
        check(req, 32'(alloc_way), 32'(w));
    endtask

    // Count negedges with ready low after a sweep command, optionally probing an allocate.
    task automatic sweep(input string req, input logic [2:0] op, input bit probe);
        int cnt;
        int bad;
        cnt = 0;
        bad = 0;
        issue(op, 5'd0, 5'd0);
        if (probe) begin
            cmd_op = 3'd5; cmd_set = 5'd6; cmd_valid = 1'b1;
        end
        while (!cmd_ready && cnt < 100) begin
            cnt++;
            @(negedge clk);
            cmd_valid = 1'b0;
            if (alloc_ok || alloc_full) bad++;
        end
        check(req, 32'(cnt), 32'd32);
        if (probe) check("R10 allocate dropped while busy", 32'(bad), 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 enable off", 32'(cfg_en), 32'd0);
        check("R1 ready high", 32'(cmd_ready), 32'd1);
        check("R1 response idle", 32'({alloc_ok, alloc_full}), 32'd0);

        // R2 disabled allocate does nothing
        issue(3'd5, 5'd1, 5'd0);
        check("R2 no alloc while disabled", 32'({alloc_ok, alloc_full}), 32'd0);
        // R10 reserved op has no effect
        issue(3'd7, 5'd5, 5'd0);
        check("R10 reserved op", 32'({alloc_ok, alloc_full}), 32'd0);
        write_cfg(32'h0000_0004);
        check("R2 enable bit 2", 32'(cfg_en), 32'd1);
        look(5'd1, 32'hFFFF_FFFF);
        check("R2 disabled alloc left set empty", 32'(lk_hit), 32'd0);

        // Vector walk: R4 R6 R7 (first entry also proves R1 pointer at 31)
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][19:17], VEC[i][16:12], VEC[i][11:7]);
            check("R4 vector ok", 32'(alloc_ok), 32'(VEC[i][6]));
            check("R5 vector full", 32'(alloc_full), 32'(VEC[i][5]));
            if (VEC[i][6]) check("R4 vector way", 32'(alloc_way), 32'(VEC[i][4:0]));
        end

        // R4 pointer wraps from 31 to 0
        for (int k = 6; k < 32; k++) alloc_expect("R4 advance", 5'd7, 5'(k));
        alloc_expect("R4 wrap to 0", 5'd7, 5'd0);

        // R5 all ways locked
        for (int w = 0; w < 32; w++) issue(3'd4, 5'd12, 5'(w));
        issue(3'd5, 5'd12, 5'd0);
        check("R5 full flag", 32'(alloc_full), 32'd1);
        check("R5 no ok", 32'(alloc_ok), 32'd0);
        alloc_expect("R5 R6 pointer unchanged", 5'd7, 5'd1);

        // R3 lookups
        look(5'd7, 32'h0000_0002);
        check("R3 hit", 32'(lk_hit), 32'd1);
        check("R3 hit way", 32'(lk_hit_way), 32'd1);
        look(5'd5, 32'h0000_0009);
        check("R3 lowest way", 32'(lk_hit_way), 32'd0);
        look(5'd5, 32'h0000_0002);
        check("R3 invalidated line misses", 32'(lk_hit), 32'd0);
        lk_valid = 1'b0;
        look(5'd7, 32'h0000_0002);
        lk_valid = 1'b0; #1;
        check("R3 no lookup no hit", 32'(lk_hit), 32'd0);

        // R2 disable hides hits
        write_cfg(32'h0000_00FB);
        look(5'd7, 32'h0000_0002);
        check("R2 disabled miss", 32'(lk_hit), 32'd0);
        write_cfg(32'h0000_0004);

        // R8 invalidate all spares locked lines
        sweep("R8 ready low 32 cycles", 3'd2, 1'b0);
        look(5'd12, 32'h0000_0080);
        check("R8 locked line stays", 32'(lk_hit), 32'd1);
        look(5'd7, 32'h0000_0002);
        check("R8 unlocked line cleared", 32'(lk_hit), 32'd0);
        look(5'd5, 32'h0000_0004);
        check("R8 locked s5w2 stays", 32'(lk_hit), 32'd1);

        // R7 invalidate entry on locked line keeps the lock
        issue(3'd1, 5'd5, 5'd2);
        look(5'd5, 32'h0000_0004);
        check("R7 locked line invalid", 32'(lk_hit), 32'd0);
        alloc_expect("R7 still skipped", 5'd5, 5'd3);

        // R9 R10 unlock all with a blocked allocate
        sweep("R9 ready low 32 cycles", 3'd3, 1'b1);
        alloc_expect("R9 R10 freed set allocates", 5'd12, 5'd4);
        sweep("R8 second sweep", 3'd2, 1'b0);
        look(5'd9, 32'h0000_0001);
        check("R9 unlocked line now invalidated", 32'(lk_hit), 32'd0);

        // R11 lookup and invalidate in the same cycle
        alloc_expect("R11 setup", 5'd20, 5'd5);
        @(negedge clk);
        lk_valid = 1'b1; lk_set = 5'd20; lk_match = 32'h0000_0020;
        cmd_op = 3'd1; cmd_set = 5'd20; cmd_way = 5'd5; cmd_valid = 1'b1;
        #1;
        check("R11 hit before edge", 32'(lk_hit), 32'd1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check("R11 miss after edge", 32'(lk_hit), 32'd0);

        // R1 reset clears locks, valids, enable and pointer
        issue(3'd4, 5'd3, 5'd1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enable cleared", 32'(cfg_en), 32'd0);
        check("R1 ready after reset", 32'(cmd_ready), 32'd1);
        write_cfg(32'h0000_0004);
        look(5'd12, 32'h0000_0010);
        check("R1 valid cleared", 32'(lk_hit), 32'd0);
        alloc_expect("R1 pointer back to 31", 5'd3, 5'd0);
        alloc_expect("R1 lock cleared", 5'd3, 5'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule